// File: doc/BRIEF.md
# Two-Wire Register File Target with Interrupt Flags and Staged Writes

This block is a two-wire serial target (I2C, 7-bit addressing) that gives a host controller byte access to a space of 2^AW eight-bit registers. The first byte of a write transaction after the device address loads an address pointer. Every later byte in that transaction lands at the pointer, and the pointer then advances. A read transaction returns the byte at the pointer and advances it. So a host can read from the current pointer, or it can load the pointer with a short write and follow it with a repeated start and a read. Reads continue for as long as the host acknowledges each byte.

Two registers collect event strobes from on-chip logic as sticky flags. Software clears a flag by writing a 1 to its bit. Two matching enable registers decide which flags reach the single active-high interrupt line. A control register can switch a block of consecutive registers into a staged mode. In that mode host writes to the block fill a shadow copy, and the active copy changes only when software sets a commit field. A local peek port shows the active register contents to the surrounding logic. SCL and SDA are sampled by the block clock through synchronizers. The block never stretches the clock.

Top module: `i2c_regslv`

## Requirements
- R1: After a START, the target acknowledges a device address byte whose upper seven bits equal DEV_ADDR. With bit 0 equal to 0 (write), the next byte loads the pointer and each later byte is stored at the pointer, which then increments. Each of these bytes is acknowledged.
- R2: A device address that does not match is not acknowledged (SDA stays released), and the bytes that follow change no register.
- R3: A short write that loads the pointer, followed by a repeated START and the device address with bit 0 equal to 1, returns the register at that pointer, most significant bit first.
- R4: A read that starts directly with the device address (bit 0 = 1) returns the register at the current pointer, which is one past the last register written or read.
- R5: In a read, each host acknowledge makes the target send the register at the next address. A host not-acknowledge followed by STOP leaves SDA released (sda_oe = 0).
- R6: The pointer wraps from the highest address to 0, for writes and for reads.
- R7: evt_in[7:0] set bits of the flag register at 0xE8 and evt_in[15:8] set bits of the flag register at 0xE9. Set flags stay set and can be read back.
- R8: Writing a 1 to a flag bit clears it, and writing 0 leaves it unchanged. An event on a bit in the same cycle as its clear leaves the flag set.
- R9: irq is active high and is 1 exactly when some flag bit in 0xE8 or 0xE9 has its enable bit set in 0xEA or 0xEB.
- R10: While bit 4 of the control register 0xC1 is 1, writes to 0xC2..0xCF go to a shadow copy and leave the active value unchanged. Writes outside that range, and all writes while bit 4 is 0, change the active value directly.
- R11: Writing a nonzero value to bits 1:0 of 0xC1 copies the shadow values of 0xC2..0xCF into the active registers on the next clock, and bits 1:0 then read back as 0.
- R12: After reset every register reads 0, irq is 0 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, used to sample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen on the pad |
| sda_in | input | 1 | Serial data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| evt_in | input | 16 | Event strobes; bits 7:0 feed flags 0xE8, bits 15:8 feed flags 0xE9 |
| peek_addr | input | AW | Address of the active register shown on peek_data |
| peek_data | output | 8 | Active value of register peek_addr |
| irq | output | 1 | Active-high interrupt request |

## Verification
A flag clear and a new event on the same flag bit can land in the same clock cycle. The clear comes from a host write strobe, and that strobe's cycle depends on the serial timing. To make the two meet, the bench holds one event input high for the whole clearing transaction, so the event is present in whatever cycle the write strobe fires. The bench then reads the flag register back over the bus and expects the held bit to stay set while a bit cleared in the same write, with no event on it, drops. A commit request can likewise follow a staged write, and the bench judges it through the peek port before and after the commit.

// File: rtl/i2c_regslv_pkg.sv
package i2c_regslv_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_ACK,
      PH_WR,
      PH_TX,
      PH_MACK
   } ph_state_e;

   localparam int BYTE_W = 8;

endpackage

// File: rtl/i2c_regslv_phy.sv
module i2c_regslv_phy
   import i2c_regslv_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h2C,
   parameter int          SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              sda_oe,
   output logic              ptr_set,
   output logic              wr_stb,
   output logic              rd_stb,
   output logic [BYTE_W-1:0] wbyte,
   input  logic [BYTE_W-1:0] rd_byte,
   output logic              stop_det
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] scl_sr, sda_sr;
   logic scl_s, sda_s, scl_q, sda_q;
   logic scl_rise, scl_fall, start_det;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sr <= '1;
         sda_sr <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_sr <= {scl_sr[SYNC_STAGES-2:0], scl_in};
         sda_sr <= {sda_sr[SYNC_STAGES-2:0], sda_in};
         scl_q  <= scl_sr[SYNC_STAGES-1];
         sda_q  <= sda_sr[SYNC_STAGES-1];
      end
   end

   assign scl_s     = scl_sr[SYNC_STAGES-1];
   assign sda_s     = sda_sr[SYNC_STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

   ph_state_e         st;
   logic [3:0]        cnt;
   logic [BYTE_W-1:0] sh;
   logic              rw_q, first_q, drv_q, nak_q;
   logic              wr_done;

   assign wr_done = (st == PH_WR) && scl_fall && (cnt == 4'd8);
   assign ptr_set = wr_done & first_q;
   assign wr_stb  = wr_done & ~first_q;
   assign rd_stb  = scl_fall && (((st == PH_ACK) && rw_q) || ((st == PH_MACK) && !nak_q));
   assign wbyte   = sh;
   assign sda_oe  = drv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= PH_IDLE;
         cnt     <= '0;
         sh      <= '0;
         rw_q    <= 1'b0;
         first_q <= 1'b0;
         drv_q   <= 1'b0;
         nak_q   <= 1'b0;
      end else if (start_det) begin
         st    <= PH_ADDR;
         cnt   <= '0;
         drv_q <= 1'b0;
      end else if (stop_det) begin
         st    <= PH_IDLE;
         drv_q <= 1'b0;
      end else begin
         unique case (st)
            PH_ADDR, PH_WR: begin
               if (scl_rise) begin
                  sh  <= {sh[BYTE_W-2:0], sda_s};
                  cnt <= cnt + 4'd1;
               end
               if (scl_fall && cnt == 4'd8) begin
                  cnt <= '0;
                  if (st == PH_ADDR) begin
                     if (sh[7:1] == DEV_ADDR) begin
                        drv_q   <= 1'b1;
                        rw_q    <= sh[0];
                        first_q <= 1'b1;
                        st      <= PH_ACK;
                     end else begin
                        st <= PH_IDLE;
                     end
                  end else begin
                     drv_q   <= 1'b1;
                     first_q <= 1'b0;
                     st      <= PH_ACK;
                  end
               end
            end
            PH_ACK: begin
               if (scl_fall) begin
                  cnt <= '0;
                  if (rw_q) begin
                     sh    <= rd_byte;
                     drv_q <= ~rd_byte[7];
                     st    <= PH_TX;
                  end else begin
                     drv_q <= 1'b0;
                     st    <= PH_WR;
                  end
               end
            end
            PH_TX: begin
               if (scl_fall) begin
                  if (cnt == 4'd7) begin
                     drv_q <= 1'b0;
                     cnt   <= '0;
                     st    <= PH_MACK;
                  end else begin
                     sh    <= {sh[BYTE_W-2:0], 1'b0};
                     drv_q <= ~sh[6];
                     cnt   <= cnt + 4'd1;
                  end
               end
            end
            PH_MACK: begin
               if (scl_rise) nak_q <= sda_s;
               if (scl_fall) begin
                  if (!nak_q) begin
                     sh    <= rd_byte;
                     drv_q <= ~rd_byte[7];
                     cnt   <= '0;
                     st    <= PH_TX;
                  end else begin
                     st <= PH_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/i2c_regslv_regs.sv
module i2c_regslv_regs
   import i2c_regslv_pkg::*;
#(
   parameter int AW       = 8,
   parameter int FLAG_A0  = 'hE8,
   parameter int FLAG_A1  = 'hE9,
   parameter int EN_A0    = 'hEA,
   parameter int EN_A1    = 'hEB,
   parameter int CTRL_A   = 'hC1,
   parameter int BUF_LO   = 'hC2,
   parameter int BUF_HI   = 'hCF,
   parameter int DBUF_BIT = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ptr_set,
   input  logic                wr_stb,
   input  logic                rd_stb,
   input  logic [BYTE_W-1:0]   wbyte,
   output logic [BYTE_W-1:0]   rd_byte,
   input  logic [2*BYTE_W-1:0] evt_in,
   input  logic [AW-1:0]       peek_addr,
   output logic [BYTE_W-1:0]   peek_data,
   output logic                irq,
   output logic [2*BYTE_W-1:0] flags,
   output logic [2*BYTE_W-1:0] enables,
   output logic [BYTE_W-1:0]   ctrl,
   output logic [AW-1:0]       ptr
);

   localparam int DEPTH = 1 << AW;

   if (AW < 1 || AW > BYTE_W) begin : g_bad_aw
      $error("AW must lie in 1..8");
   end
   if (BUF_LO > BUF_HI || BUF_HI >= DEPTH) begin : g_bad_range
      $error("staged range is malformed");
   end
   if ((CTRL_A >= BUF_LO && CTRL_A <= BUF_HI) ||
       (FLAG_A0 >= BUF_LO && FLAG_A0 <= BUF_HI) ||
       (FLAG_A1 >= BUF_LO && FLAG_A1 <= BUF_HI)) begin : g_bad_overlap
      $error("control or flag register inside staged range");
   end
   if (DBUF_BIT < 2 || DBUF_BIT >= BYTE_W) begin : g_bad_bit
      $error("DBUF_BIT must not overlap the commit field");
   end

   logic [BYTE_W-1:0] act [DEPTH];
   logic              dbuf_on, commit;

   assign dbuf_on = act[CTRL_A][DBUF_BIT];
   assign commit  = |act[CTRL_A][1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                ptr <= '0;
      else if (ptr_set)          ptr <= wbyte[AW-1:0];
      else if (wr_stb || rd_stb) ptr <= ptr + 1'b1;
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [BYTE_W-1:0] q;
      logic              hit;
      assign hit    = wr_stb && (ptr == AW'(i));
      assign act[i] = q;

      if (i == FLAG_A0 || i == FLAG_A1) begin : g_flag
         localparam int EOFS = (i == FLAG_A0) ? 0 : BYTE_W;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= (hit ? (q & ~wbyte) : q) | evt_in[EOFS +: BYTE_W];
         end
      end else if (i == CTRL_A) begin : g_ctrl
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q <= '0;
            else if (hit)    q <= wbyte;
            else if (commit) q <= {q[BYTE_W-1:2], 2'b00};
         end
      end else if (i >= BUF_LO && i <= BUF_HI) begin : g_stage
         logic [BYTE_W-1:0] shd;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q   <= '0;
               shd <= '0;
            end else begin
               if (hit && dbuf_on)       shd <= wbyte;
               if (hit && !dbuf_on)      q   <= wbyte;
               else if (commit)          q   <= shd;
            end
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= wbyte;
         end
      end
   end

   assign rd_byte   = act[ptr];
   assign peek_data = act[peek_addr];
   assign flags     = {act[FLAG_A1], act[FLAG_A0]};
   assign enables   = {act[EN_A1], act[EN_A0]};
   assign ctrl      = act[CTRL_A];
   assign irq       = |((act[FLAG_A0] & act[EN_A0]) | (act[FLAG_A1] & act[EN_A1]));

endmodule

// File: rtl/i2c_regslv.sv
module i2c_regslv
   import i2c_regslv_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h2C,
   parameter int          AW          = 8,
   parameter int          SYNC_STAGES = 2,
   parameter int          CTRL_A      = 'hC1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                scl_in,
   input  logic                sda_in,
   output logic                sda_oe,
   input  logic [15:0]         evt_in,
   input  logic [AW-1:0]       peek_addr,
   output logic [7:0]          peek_data,
   output logic                irq
);

   logic              ptr_set_w, wr_stb_w, rd_stb_w, stop_w;
   logic [BYTE_W-1:0] wbyte_w, rd_byte_w, ctrl_w;
   logic [15:0]       flag_w, en_w;
   logic [AW-1:0]     ptr_w;

   i2c_regslv_phy #(
      .DEV_ADDR   (DEV_ADDR),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_phy (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_in  (scl_in),
      .sda_in  (sda_in),
      .sda_oe  (sda_oe),
      .ptr_set (ptr_set_w),
      .wr_stb  (wr_stb_w),
      .rd_stb  (rd_stb_w),
      .wbyte   (wbyte_w),
      .rd_byte (rd_byte_w),
      .stop_det(stop_w)
   );

   i2c_regslv_regs #(
      .AW    (AW),
      .CTRL_A(CTRL_A)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .ptr_set  (ptr_set_w),
      .wr_stb   (wr_stb_w),
      .rd_stb   (rd_stb_w),
      .wbyte    (wbyte_w),
      .rd_byte  (rd_byte_w),
      .evt_in   (evt_in),
      .peek_addr(peek_addr),
      .peek_data(peek_data),
      .irq      (irq),
      .flags    (flag_w),
      .enables  (en_w),
      .ctrl     (ctrl_w),
      .ptr      (ptr_w)
   );

endmodule

// File: rtl/i2c_regslv_chk.sv
module i2c_regslv_chk #(
   parameter int AW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic [15:0]   evt_in,
   input logic [15:0]   flags,
   input logic [15:0]   enables,
   input logic          irq,
   input logic [7:0]    ctrl,
   input logic [AW-1:0] ptr,
   input logic          ptr_set,
   input logic          wr_stb,
   input logic          rd_stb,
   input logic          stop_det,
   input logic          sda_oe
);

   // R8: an event always lands, even when a clear hits the same cycle
   a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_in != 16'h0) |=> ((flags & $past(evt_in)) == $past(evt_in)));

   // R9: with every enable cleared the line stays low
   a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (enables == 16'h0) |-> !irq);

   // R11: commit field drops one clock after it was seen
   a_r11_commit_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
      ((ctrl[1:0] != 2'b00) && !wr_stb) |=> (ctrl[1:0] == 2'b00));

   // R6: pointer wraps from all ones to zero
   a_r6_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_stb || rd_stb) && !ptr_set && (ptr == {AW{1'b1}})) |=> (ptr == '0));

   // R5: a STOP leaves the data line released
   a_r5_release_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe);

endmodule

bind i2c_regslv i2c_regslv_chk #(.AW(AW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .evt_in  (evt_in),
   .flags   (flag_w),
   .enables (en_w),
   .irq     (irq),
   .ctrl    (ctrl_w),
   .ptr     (ptr_w),
   .ptr_set (ptr_set_w),
   .wr_stb  (wr_stb_w),
   .rd_stb  (rd_stb_w),
   .stop_det(stop_w),
   .sda_oe  (sda_oe)
);

// File: tb/i2c_regslv_bench.sv
module i2c_regslv_bench;

   localparam logic [6:0] DEV = 7'h2C;
   localparam int         Q   = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1;
   logic        sda_m = 1'b1;
   logic [15:0] evt = '0;
   logic [7:0]  peek_addr = '0;
   logic [7:0]  peek_data;
   logic        sda_oe, irq;
   wire         sda_line = sda_m & ~sda_oe;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   typedef struct {
      logic [7:0] d;
      string      tag;
   } exp_t;
   exp_t       exp_q[$];
   event       ev_rx;
   logic [7:0] rx_byte;

   always #2.5 clk = ~clk;

   i2c_regslv #(.DEV_ADDR(DEV)) u_i2c_regslv (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_in   (scl_m),
      .sda_in   (sda_line),
      .sda_oe   (sda_oe),
      .evt_in   (evt),
      .peek_addr(peek_addr),
      .peek_data(peek_data),
      .irq      (irq)
   );

   task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: pops one expected byte per received byte
   initial begin
      forever begin
         @(ev_rx);
         if (exp_q.size() == 0) begin
            check(1'b0, "unexpected byte", rx_byte, 8'h00);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(rx_byte === e.d, e.tag, rx_byte, e.d);
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bstart();
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic bstop();
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b1; tick(2 * Q);
   endtask

   task automatic bbit(input logic b, output logic s);
      sda_m = b;    tick(Q);
      scl_m = 1'b1; tick(Q);
      s = sda_line; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      logic s;
      for (int i = 7; i >= 0; i--) bbit(b[i], s);
      bbit(1'b1, s);
      ack = !s;
   endtask

   task automatic recv_byte(input bit mack);
      logic [7:0] d;
      logic       s;
      for (int i = 7; i >= 0; i--) begin
         bbit(1'b1, s);
         d[i] = s;
      end
      bbit(!mack, s);
      rx_byte = d;
      -> ev_rx;
   endtask

   task automatic expect_byte(input logic [7:0] d, input string tag);
      exp_t e;
      e.d = d;
      e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic addr_phase(input bit rd, input string tag);
      bit ack;
      send_byte({DEV, rd}, ack);
      check(ack, {tag, " device ack"}, {7'h0, ack}, 8'h01);
   endtask

   task automatic wr_regs(input logic [7:0] a, input logic [7:0] d0, input logic [7:0] d1, input int n);
      bit ack;
      bstart();
      addr_phase(1'b0, "R1");
      send_byte(a, ack);
      check(ack, "R1 word ack", {7'h0, ack}, 8'h01);
      send_byte(d0, ack);
      check(ack, "R1 data ack", {7'h0, ack}, 8'h01);
      if (n > 1) send_byte(d1, ack);
      bstop();
   endtask

   task automatic rd_rand(input logic [7:0] a, input int n);
      bit ack;
      bstart();
      addr_phase(1'b0, "R3");
      send_byte(a, ack);
      bstart();
      addr_phase(1'b1, "R3");
      for (int i = 0; i < n; i++) recv_byte(i < n - 1);
      bstop();
   endtask

   task automatic rd_cur(input int n);
      bstart();
      addr_phase(1'b1, "R4");
      for (int i = 0; i < n; i++) recv_byte(i < n - 1);
      bstop();
   endtask

   task automatic peek_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
      peek_addr = a;
      tick(1);
      check(peek_data === exp, tag, peek_data, exp);
   endtask

   task automatic pulse(input int bitno);
      evt[bitno] = 1'b1;
      tick(1);
      evt[bitno] = 1'b0;
      tick(2);
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=%h expected=%h", 8'h00, 8'h01);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      bit ack;
      tick(4);
      rst_n = 1'b1;
      tick(4);

      // R12: reset state
      check(irq === 1'b0, "R12 irq", {7'h0, irq}, 8'h00);
      check(sda_oe === 1'b0, "R12 sda", {7'h0, sda_oe}, 8'h00);
      peek_chk(8'h10, 8'h00, "R12 reg");

      // R1: two-byte write with auto increment
      wr_regs(8'h10, 8'hA5, 8'h5A, 2);
      peek_chk(8'h10, 8'hA5, "R1 first byte");
      peek_chk(8'h11, 8'h5A, "R1 second byte");

      // R2: foreign address is ignored
      bstart();
      send_byte({7'h21, 1'b0}, ack);
      check(!ack, "R2 no ack", {7'h0, ack}, 8'h00);
      send_byte(8'h10, ack);
      send_byte(8'hEE, ack);
      bstop();
      peek_chk(8'h10, 8'hA5, "R2 reg untouched");

      // R3: random read; R4: current-address read
      expect_byte(8'hA5, "R3 random read");
      rd_rand(8'h10, 1);
      expect_byte(8'h5A, "R4 current read");
      rd_cur(1);

      // R5: sequential read, then release
      expect_byte(8'hA5, "R5 seq byte 0");
      expect_byte(8'h5A, "R5 seq byte 1");
      expect_byte(8'h00, "R5 seq byte 2");
      rd_rand(8'h10, 3);
      check(sda_oe === 1'b0, "R5 released", {7'h0, sda_oe}, 8'h00);
      expect_byte(8'h00, "R4 pointer after seq");
      rd_cur(1);

      // R6: wrap on write and on read
      wr_regs(8'hFF, 8'h77, 8'h88, 2);
      peek_chk(8'hFF, 8'h77, "R6 top byte");
      peek_chk(8'h00, 8'h88, "R6 wrapped write");
      expect_byte(8'h77, "R6 read top");
      expect_byte(8'h88, "R6 read wrapped");
      rd_rand(8'hFF, 2);

      // R7 / R9: flags and masking
      wr_regs(8'hEA, 8'h01, 8'h00, 1);
      check(irq === 1'b0, "R9 idle", {7'h0, irq}, 8'h00);
      pulse(0);
      check(irq === 1'b1, "R9 enabled flag", {7'h0, irq}, 8'h01);
      pulse(1);
      expect_byte(8'h03, "R7 flags low");
      rd_rand(8'hE8, 1);

      // R8: write-1-to-clear
      wr_regs(8'hE8, 8'h01, 8'h00, 1);
      check(irq === 1'b0, "R9 masked flag left", {7'h0, irq}, 8'h00);
      expect_byte(8'h02, "R8 w1c");
      rd_rand(8'hE8, 1);

      // R8: event held through its own clear
      evt[2] = 1'b1;
      wr_regs(8'hE8, 8'h06, 8'h00, 1);
      evt[2] = 1'b0;
      tick(2);
      expect_byte(8'h04, "R8 event wins");
      rd_rand(8'hE8, 1);

      // R7 / R9: upper pair
      wr_regs(8'hEB, 8'h80, 8'h00, 1);
      pulse(15);
      check(irq === 1'b1, "R9 upper pair", {7'h0, irq}, 8'h01);
      expect_byte(8'h80, "R7 flags high");
      rd_rand(8'hE9, 1);
      wr_regs(8'hE9, 8'h80, 8'h00, 1);
      check(irq === 1'b0, "R9 upper cleared", {7'h0, irq}, 8'h00);

      // R10 / R11: staged writes and commit
      wr_regs(8'hC1, 8'h10, 8'h00, 1);
      wr_regs(8'hC5, 8'h33, 8'h00, 1);
      peek_chk(8'hC5, 8'h00, "R10 staged held");
      wr_regs(8'hD0, 8'h44, 8'h00, 1);
      peek_chk(8'hD0, 8'h44, "R10 outside range");
      wr_regs(8'hC1, 8'h11, 8'h00, 1);
      peek_chk(8'hC5, 8'h33, "R11 committed");
      peek_chk(8'hC1, 8'h10, "R11 self clear");
      expect_byte(8'h10, "R11 ctrl readback");
      rd_rand(8'hC1, 1);
      wr_regs(8'hC1, 8'h00, 8'h00, 1);
      wr_regs(8'hC5, 8'h99, 8'h00, 1);
      peek_chk(8'hC5, 8'h99, "R10 direct when off");

      tick(4);
      check(exp_q.size() == 0, "scoreboard drained", 8'(exp_q.size()), 8'h00);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule